// File: doc/BRIEF.md
# Flash Program Completion Poller

This block runs on the host side of a flash memory. Software or a sequencer starts it once a program or erase operation has been launched in the device. The start request carries the word address being written (or any address inside the block being erased) and the data that was written. The poller then reads that address over and over through a simple request/response read port. Each returned word is judged by two status bits. A completion bit reflects the true data once the operation has finished. An error bit reports that the internal controller gave up. While the operation runs, any read inside the busy bank returns status instead of array data, so the polled address must lie in the bank being modified.

The completion bit can flip in the same moment that the error bit is raised. For that reason a raised error bit does not fail the operation at once. The poller makes one more read and bases its verdict on that word alone. A limit on the number of polls, loaded with each start, guards against a device that never finishes. Running out of polls gives a fail verdict together with a separate timeout flag. The verdict appears as a one-cycle done pulse, with the pass, fail and timeout flags valid in that same cycle.

Top module: `flash_poll_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with no start, done_o, pass_o, fail_o, timeout_o and rd_req_o are all 0.
- R2: start_i is accepted only when the poller is idle. A start_i seen while rd_req_o is high changes neither the polled address nor the outcome of the running operation.
- R3: While the poller is busy, rd_req_o is high and rd_addr_o equals the address captured at start. A request stays up with a stable address until a cycle in which rd_valid_i is high, and that cycle takes rd_data_i as the response.
- R4: The completion bit is bit 7 of rd_data_i. A response whose bit 7 equals the expected bit ends the operation with pass. done_o and pass_o are high in the cycle after that response.
- R5: A response whose bit 7 differs from the expected bit while bit 5 (the error bit) is 0 is one busy poll. If polls remain, rd_req_o stays high in the next cycle for a new read of the same address.
- R6: A response with a bit 7 mismatch and bit 5 at 1 causes exactly one further read. The verdict is pass if that read's bit 7 matches and fail if it does not, and timeout_o stays 0. This extra read is not limited by the poll count.
- R7: When erase_i is 1 at start, the expected completion bit is 1 whatever start_data_i holds. Otherwise the expected bit is bit 7 of start_data_i.
- R8: poll_limit_i, sampled at start, bounds the busy polls. The busy response that makes the count of busy polls equal to the limit ends the operation with fail_o and timeout_o high. A limit of 0 acts as 1.
- R9: done_o is high for exactly one cycle per operation. In that cycle exactly one of pass_o and fail_o is high. Outside it, pass_o, fail_o and timeout_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a completion check (taken when idle) |
| start_addr_i | input | ADDR_W | Word address to poll |
| start_data_i | input | DATA_W | Data that was programmed |
| erase_i | input | 1 | Operation is an erase (expected completion bit 1) |
| poll_limit_i | input | CNT_W | Maximum number of busy polls |
| rd_req_o | output | 1 | Read request, held until answered |
| rd_addr_o | output | ADDR_W | Read address |
| rd_valid_i | input | 1 | Response valid, completes the pending read |
| rd_data_i | input | DATA_W | Response word |
| done_o | output | 1 | One-cycle verdict pulse |
| pass_o | output | 1 | Operation completed correctly (with done_o) |
| fail_o | output | 1 | Operation failed or timed out (with done_o) |
| timeout_o | output | 1 | Poll limit exhausted (with done_o) |

## Verification
An accepted start raises rd_req_o in the following cycle. After a busy response, the request stays up in the next cycle. After a response with the error bit set, the next request is the single re-read. The verdict flags appear one cycle after the response that decides them. The bench drives inputs and samples outputs on the falling edge. It advances a behavioural model by the same clock edge and compares the request, address and all four verdict flags on every cycle. Each scenario also checks its final verdict against an outcome fixed by hand.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  typedef enum logic [1:0] {
    PS_IDLE    = 2'd0,
    PS_POLL    = 2'd1,
    PS_RECHECK = 2'd2
  } poll_state_e;
endpackage

// File: rtl/poll_status_decode.sv
module poll_status_decode #(
  parameter int DATA_W   = 16,
  parameter int DONE_BIT = 7,
  parameter int ERR_BIT  = 5
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic              expect_i,
  output logic              match_o,
  output logic              err_o
);
  logic unused_word;
  assign unused_word = ^word_i;

  assign match_o = (word_i[DONE_BIT] == expect_i);
  assign err_o   = word_i[ERR_BIT];
endmodule

// File: rtl/poll_attempt_counter.sv
module poll_attempt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             step_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim_q, lim_d;

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    if (load_i) begin
      cnt_d = '0;
      lim_d = limit_i;
    end else if (step_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end

  // the poll being judged is number cnt_q+1; a limit of zero behaves as one
  assign last_o = ({1'b0, cnt_q} + 1'b1) >= {1'b0, lim_q};

  // R8
  count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) || (cnt_q < lim_q));
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 16,
  parameter int DONE_BIT = 7,
  parameter int ERR_BIT  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [DATA_W-1:0] start_data_i,
  input  logic              erase_i,
  input  logic [CNT_W-1:0]  poll_limit_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic              timeout_o
);
  poll_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              exp_q;
  logic              capture;
  logic              step;
  logic              last_poll;
  logic              hit, err_seen;
  logic              done_d, pass_d, fail_d, tmo_d;
  logic              done_q, pass_q, fail_q, tmo_q;
  logic              unused_start;

  assign unused_start = ^start_data_i;

  poll_status_decode #(
    .DATA_W  (DATA_W),
    .DONE_BIT(DONE_BIT),
    .ERR_BIT (ERR_BIT)
  ) u_decode (
    .word_i  (rd_data_i),
    .expect_i(exp_q),
    .match_o (hit),
    .err_o   (err_seen)
  );

  poll_attempt_counter #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (capture),
    .limit_i(poll_limit_i),
    .step_i (step),
    .last_o (last_poll)
  );

  // next-state and verdict logic
  always_comb begin
    state_d = state_q;
    capture = 1'b0;
    step    = 1'b0;
    done_d  = 1'b0;
    pass_d  = 1'b0;
    fail_d  = 1'b0;
    tmo_d   = 1'b0;
    unique case (state_q)
      PS_IDLE: begin
        if (start_i) begin
          capture = 1'b1;
          state_d = PS_POLL;
        end
      end
      PS_POLL: begin
        if (rd_valid_i) begin
          if (hit) begin
            done_d  = 1'b1;
            pass_d  = 1'b1;
            state_d = PS_IDLE;
          end else if (err_seen) begin
            state_d = PS_RECHECK;
          end else if (last_poll) begin
            done_d  = 1'b1;
            fail_d  = 1'b1;
            tmo_d   = 1'b1;
            state_d = PS_IDLE;
          end else begin
            step = 1'b1;
          end
        end
      end
      PS_RECHECK: begin
        if (rd_valid_i) begin
          done_d  = 1'b1;
          pass_d  = hit;
          fail_d  = !hit;
          state_d = PS_IDLE;
        end
      end
      default: state_d = PS_IDLE;
    endcase
  end

  // state and verdict registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_IDLE;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      pass_q  <= pass_d;
      fail_q  <= fail_d;
      tmo_q   <= tmo_d;
    end
  end

  // operation context, enabled on capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      exp_q  <= 1'b0;
    end else if (capture) begin
      addr_q <= start_addr_i;
      exp_q  <= erase_i ? 1'b1 : start_data_i[DONE_BIT];
    end
  end

  assign rd_req_o  = (state_q != PS_IDLE);
  assign rd_addr_o = addr_q;
  assign done_o    = done_q;
  assign pass_o    = pass_q;
  assign fail_o    = fail_q;
  assign timeout_o = tmo_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R9
  verdict_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (pass_o ^ fail_o));
  // R9
  flags_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> !(pass_o || fail_o || timeout_o));
  // R8
  timeout_is_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> fail_o);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o)));
  // R2
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && start_i) |=> $stable(rd_addr_o));
  // R6
  recheck_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_RECHECK && rd_valid_i) |=> (done_o && !timeout_o));
  // R1
  idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !rd_req_o);
endmodule

// File: tb/flash_poll_ctrl_test.sv
`timescale 1ns/1ps
module flash_poll_ctrl_test;
  localparam int AW = 21;
  localparam int DW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [AW-1:0] start_addr_i;
  logic [DW-1:0] start_data_i;
  logic          erase_i;
  logic [CW-1:0] poll_limit_i;
  logic          rd_req_o;
  logic [AW-1:0] rd_addr_o;
  logic          rd_valid_i;
  logic [DW-1:0] rd_data_i;
  logic          done_o, pass_o, fail_o, timeout_o;

  always #2.5 clk = ~clk;

  flash_poll_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .start_data_i(start_data_i), .erase_i(erase_i), .poll_limit_i(poll_limit_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i),
    .rd_data_i(rd_data_i), .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o),
    .timeout_o(timeout_o)
  );

  int checks = 0;
  int errors = 0;
  string cur_tag = "R4";

  // responder
  logic [DW-1:0] rsp_q[$];
  int lat = 0;
  int wcnt = 0;

  // behavioural model: phase 0 idle, 1 polling, 2 final re-read
  int  m_phase = 0;
  int  m_addr = 0;
  int  m_exp = 0;
  int  m_busy = 0;
  int  m_lim = 1;
  bit  m_done = 0, m_pass = 0, m_fail = 0, m_to = 0;
  bit  seen_done = 0, seen_pass = 0, seen_to = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic tick(input bit st, input int a, input int d, input bit er, input int lim);
    bit vld;
    int rsp;
    @(negedge clk);
    check(rd_req_o === (m_phase != 0), "R3", "rd_req_o", rd_req_o, m_phase != 0);
    if (m_phase != 0)
      check(rd_addr_o === AW'(m_addr), "R3", "rd_addr_o", rd_addr_o, m_addr);
    check(done_o === m_done, "R9", "done_o", done_o, m_done);
    check(pass_o === m_pass, cur_tag, "pass_o", pass_o, m_pass);
    check(fail_o === m_fail, cur_tag, "fail_o", fail_o, m_fail);
    check(timeout_o === m_to, cur_tag, "timeout_o", timeout_o, m_to);
    seen_done = done_o; seen_pass = pass_o; seen_to = timeout_o;
    start_i = st; start_addr_i = AW'(a); start_data_i = DW'(d);
    erase_i = er; poll_limit_i = CW'(lim);
    vld = 0; rsp = 0;
    if (rd_req_o && wcnt >= lat && rsp_q.size() > 0) begin
      vld = 1; rsp = int'(rsp_q.pop_front()); wcnt = 0;
    end else if (rd_req_o) begin
      wcnt++;
    end
    rd_valid_i = vld; rd_data_i = DW'(rsp);
    // model step for the coming edge
    m_done = 0; m_pass = 0; m_fail = 0; m_to = 0;
    if (m_phase == 0) begin
      if (st) begin
        m_phase = 1; m_addr = a; m_busy = 0;
        m_exp = er ? 1 : ((d >> 7) & 1);
        m_lim = (lim == 0) ? 1 : lim;
      end
    end else if (vld) begin
      if (((rsp >> 7) & 1) == m_exp) begin
        m_done = 1; m_pass = 1; m_phase = 0;
      end else if (m_phase == 2) begin
        m_done = 1; m_fail = 1; m_phase = 0;
      end else if ((rsp >> 5) & 1) begin
        m_phase = 2;
      end else begin
        m_busy++;
        if (m_busy >= m_lim) begin
          m_done = 1; m_fail = 1; m_to = 1; m_phase = 0;
        end
      end
    end
  endtask

  // one operation: start, optional busy-time start with another address, wait for verdict
  task automatic run(input string tag, input int a, input int d, input bit er, input int lim,
                     input int latency, input bit poke, input bit exp_pass, input bit exp_to);
    int n = 0;
    cur_tag = tag; lat = latency; wcnt = 0;
    tick(1, a, d, er, lim);
    seen_done = 0;
    while (!seen_done && n < 400) begin
      tick(poke && n == 1, a ^ 'h1555, d ^ 'hFFFF, !er, 0);
      n++;
    end
    check(seen_done, tag, "verdict reached", seen_done, 1);
    check(seen_pass == exp_pass, tag, "final pass", seen_pass, exp_pass);
    check(seen_to == exp_to, tag, "final timeout", seen_to, exp_to);
    check(rsp_q.size() == 0, tag, "responses consumed", rsp_q.size(), 0);
    rsp_q.delete();
    tick(0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 0; start_addr_i = '0; start_data_i = '0;
    erase_i = 0; poll_limit_i = '0; rd_valid_i = 0; rd_data_i = '0;
    repeat (3) @(negedge clk);
    // R1 outputs quiet in reset
    check({done_o, pass_o, fail_o, timeout_o, rd_req_o} === 5'b0, "R1", "reset outputs",
          {done_o, pass_o, fail_o, timeout_o, rd_req_o}, 0);
    rst_n = 1'b1;
    cur_tag = "R1";
    repeat (3) tick(0, 0, 0, 0, 0);

    // R4 immediate completion
    rsp_q = '{16'h0080};
    run("R4", 'h12345, 'h0080, 0, 8, 0, 0, 1, 0);
    // R5 busy polls then completion, with response latency
    rsp_q = '{16'h0000, 16'h0040, 16'h00C3};
    run("R5", 'h1F0001, 'h00FF, 0, 8, 2, 0, 1, 0);
    // R6 error bit, re-read matches
    rsp_q = '{16'h0000, 16'h0020, 16'h00A0};
    run("R6", 'h00300, 'h0080, 0, 8, 1, 0, 1, 0);
    // R6 error bit, re-read still differs
    rsp_q = '{16'h0020, 16'h0020};
    run("R6", 'h00301, 'h0080, 0, 8, 0, 0, 0, 0);
    // R6 error on the only allowed poll still gets its re-read, no timeout
    rsp_q = '{16'h0020, 16'h0000};
    run("R6", 'h00302, 'h0080, 0, 1, 0, 0, 0, 0);
    // R7 erase expects bit7 = 1 even though data bit7 is 0
    rsp_q = '{16'h0000, 16'h0080};
    run("R7", 'h100000, 'h0000, 1, 8, 0, 0, 1, 0);
    // R7 program with expected bit7 = 0: a 1 means busy
    rsp_q = '{16'h0080, 16'h0080, 16'h0000};
    run("R7", 'h100001, 'h007F, 0, 8, 0, 0, 1, 0);
    // R8 limit exhausted
    rsp_q = '{16'h0000, 16'h0000, 16'h0000};
    run("R8", 'h0ABCD, 'h0080, 0, 3, 1, 0, 0, 1);
    // R8 limit zero acts as one
    rsp_q = '{16'h0000};
    run("R8", 'h0ABCE, 'h0080, 0, 0, 0, 0, 0, 1);
    // R2 start during busy is ignored
    rsp_q = '{16'h0000, 16'h0000, 16'h0080};
    run("R2", 'h05555, 'h0080, 0, 8, 3, 1, 1, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule